// File: doc/BRIEF.md
# Microcoded Bus Adder Datapath

This block adds two 4-bit operands under step-by-step microprogram control. An operator sets a 4-bit microaddress. A combinational control store turns that address into a 9-bit horizontal control word. The word's fields open an input buffer onto a shared bus, pick which source the bus register loads from, gate three transparent operand/result latches, and enable their outputs.

An adder feeds its result back onto the bus. A third latch captures the sum and presents it on the display port. The bus register is also visible on a bidirectional pin. The block drives that pin only while no bus write is in progress.

The listed microaddresses form a fixed sequence of named steps:

| Step | Address | Action |
| --- | --- | --- |
| STEP_IDLE | 0 | Idle |
| STEP_BUS_A | 1 | Load operand A onto the bus |
| STEP_LATCH_A | 2 | Latch A into register 1 |
| STEP_BUS_B | 3 | Load operand B onto the bus |
| STEP_LATCH_B | 4 | Latch B into register 2 |
| STEP_ADD | 5 | Write the sum onto the bus |
| STEP_LATCH_SUM | 6 | Latch the sum into register 3 |
| STEP_SHOW | 7 | Show register 3 |

An operator moves from each step to the next by changing the address switches. Addresses 8 to 15 are unlisted steps.

Top module: `ubus_adder`

## Requirements
- R1: The control word on `ctrl_word` has, from bit 0 upward, the fields: buffer enable, bus write 1 (from the buffer), bus write 2 (from the adder), gate 1, output-off 1, gate 2, output-off 2, gate 3, output-off 3. At address 0 the word is 0x151, which leaves all registers off the bus.
- R2: Addresses 1 to 7 produce these words: 0x153, 0x159, 0x153, 0x171, 0x104, 0x180 and 0x050.
- R3: Addresses 8 to 15 produce the all-zero word. Under that word the bus register keeps its value, and register 3 drives `sum_out`.
- R4: On a rising clock edge the bus register loads from the first enabled write source. Write 1 takes `opnd_in` through the buffer, or 0 when the buffer is off. Write 2 takes the adder result.
- R5: With no write enable set, the bus register holds its value across clock edges.
- R6: `bus_pin` carries the bus register value while no write enable is set. It is released to high impedance while either write enable is set.
- R7: Each register is a transparent latch that follows the bus while its gate is high and holds otherwise. Its output reads 0 while its output-off bit is 1.
- R8: The adder output is the sum of the register 1 and register 2 outputs, modulo 16, with the carry dropped. Stepping through addresses 1 to 7 leaves (A+B) mod 16 on `sum_out`.
- R9: While `rst_n` is low, the bus register and all three latches clear to 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Bus register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uaddr | input | 4 | Microaddress switches |
| opnd_in | input | 4 | Operand switches feeding the input buffer |
| ctrl_word | output | 9 | Current control word |
| sum_out | output | 4 | Register 3 output for display |
| bus_pin | inout | 4 | Bus register value, released during writes |

## Verification
A wrong control-store word shows on `ctrl_word` as soon as the address settles, with no clock needed. Its side effects follow on the next edge: a stray write enable replaces the bus value, and `bus_pin` floats. A latch that holds stale data, or that fails to hold, shows only once the sequence reaches STEP_SHOW, and the sum is then wrong. The bench therefore also checks `sum_out` and `bus_pin` after a step that must leave them untouched. An adder or bus-priority fault shows one edge after STEP_ADD, once the sum is latched and shown.

// File: rtl/ubus_pkg.sv
package ubus_pkg;
    localparam int DATA_W = 4;
    localparam int ADDR_W = 4;

    // bit 0 is buf_en, bit 8 is off3
    typedef struct packed {
        logic off3;
        logic gate3;
        logic off2;
        logic gate2;
        logic off1;
        logic gate1;
        logic wr_alu;
        logic wr_buf;
        logic buf_en;
    } uword_t;

    localparam int UWORD_W = $bits(uword_t);

    typedef enum logic [ADDR_W-1:0] {
        STEP_IDLE      = 4'd0,
        STEP_BUS_A     = 4'd1,
        STEP_LATCH_A   = 4'd2,
        STEP_BUS_B     = 4'd3,
        STEP_LATCH_B   = 4'd4,
        STEP_ADD       = 4'd5,
        STEP_LATCH_SUM = 4'd6,
        STEP_SHOW      = 4'd7
    } step_e;

    localparam logic [3:0] FN_ADD = 4'b1001;
endpackage

// File: rtl/ubus_store.sv
module ubus_store
    import ubus_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output uword_t            word
);
    always_comb begin
        word = '0;
        unique case (addr)
            STEP_IDLE:      word = 9'h151;
            STEP_BUS_A:     word = 9'h153;
            STEP_LATCH_A:   word = 9'h159;
            STEP_BUS_B:     word = 9'h153;
            STEP_LATCH_B:   word = 9'h171;
            STEP_ADD:       word = 9'h104;
            STEP_LATCH_SUM: word = 9'h180;
            STEP_SHOW:      word = 9'h050;
            default:        word = '0;
        endcase
    end
endmodule

// File: rtl/ubus_busreg.sv
module ubus_busreg #(
    parameter int W    = 4,
    parameter int N_IN = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_IN-1:0][W-1:0]   din,
    input  logic [N_IN-1:0]          we,
    output logic [W-1:0]             q,
    output logic                     drive_en
);
    logic [W-1:0] nxt;

    // lowest-numbered enabled source wins
    always_comb begin
        nxt = q;
        for (int i = N_IN - 1; i >= 0; i--) begin
            if (we[i]) nxt = din[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    assign drive_en = ~(|we);

    assert_load_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we[0] |=> (q == $past(din[0])));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we == '0) |=> $stable(q));
endmodule

// File: rtl/ubus_latch.sv
module ubus_latch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         gate,
    input  logic         off,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] held;

    always_latch begin
        if (!rst_n)    held <= '0;
        else if (gate) held <= d;
    end

    assign q = off ? '0 : held;

    assert_transparent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && !off) |-> (q == d));
endmodule

// File: rtl/ubus_alu.sv
module ubus_alu #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   fn,
    output logic [W-1:0] f
);
    always_comb begin
        if (fn == ubus_pkg::FN_ADD) f = a + b;
        else                        f = a;
    end
endmodule

// File: rtl/ubus_adder.sv
module ubus_adder
    import ubus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    uaddr,
    input  logic [DATA_W-1:0]    opnd_in,
    output logic [UWORD_W-1:0]   ctrl_word,
    output logic [DATA_W-1:0]    sum_out,
    inout  wire  [DATA_W-1:0]    bus_pin
);
    localparam int N_SRC = 2;

    uword_t                        ctl;
    logic [DATA_W-1:0]             buf_out, alu_f, bus_q, r1_q, r2_q;
    logic [N_SRC-1:0][DATA_W-1:0]  src;
    logic                          drive_en;

    ubus_store u_store (.addr(uaddr), .word(ctl));
    assign ctrl_word = ctl;

    assign buf_out = ctl.buf_en ? opnd_in : '0;
    assign src     = {alu_f, buf_out};

    ubus_busreg #(.W(DATA_W), .N_IN(N_SRC)) u_bus (
        .clk(clk), .rst_n(rst_n), .din(src),
        .we({ctl.wr_alu, ctl.wr_buf}), .q(bus_q), .drive_en(drive_en));

    ubus_latch #(.W(DATA_W)) u_r1 (.clk(clk), .rst_n(rst_n), .gate(ctl.gate1),
        .off(ctl.off1), .d(bus_q), .q(r1_q));
    ubus_latch #(.W(DATA_W)) u_r2 (.clk(clk), .rst_n(rst_n), .gate(ctl.gate2),
        .off(ctl.off2), .d(bus_q), .q(r2_q));
    ubus_latch #(.W(DATA_W)) u_r3 (.clk(clk), .rst_n(rst_n), .gate(ctl.gate3),
        .off(ctl.off3), .d(bus_q), .q(sum_out));

    ubus_alu #(.W(DATA_W)) u_alu (.a(r1_q), .b(r2_q), .fn(FN_ADD), .f(alu_f));

    assign bus_pin = drive_en ? bus_q : 'z;

    assert_alu_to_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.wr_alu && !ctl.wr_buf) |=> (bus_q == DATA_W'($past(r1_q) + $past(r2_q))));
endmodule

// File: tb/ubus_adder_bench.sv
module ubus_adder_bench;
    localparam int CLK_PER = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [3:0] uaddr = 0;
    logic [3:0] opnd_in = 0;
    logic [8:0] ctrl_word;
    logic [3:0] sum_out;
    wire  [3:0] bus_pin;
    logic       ext_en = 0;
    logic [3:0] ext_val = 0;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    assign bus_pin = ext_en ? ext_val : 4'bz;

    always #(CLK_PER/2) clk = ~clk;

    ubus_adder u_ubus_adder (.clk(clk), .rst_n(rst_n), .uaddr(uaddr),
        .opnd_in(opnd_in), .ctrl_word(ctrl_word), .sum_out(sum_out), .bus_pin(bus_pin));

    function automatic logic [8:0] exp_word(input logic [3:0] a);
        case (a)
            4'd0: return 9'h151;
            4'd1: return 9'h153;
            4'd2: return 9'h159;
            4'd3: return 9'h153;
            4'd4: return 9'h171;
            4'd5: return 9'h104;
            4'd6: return 9'h180;
            4'd7: return 9'h050;
            default: return 9'h000;
        endcase
    endfunction

    function automatic logic [3:0] exp_sum(input logic [3:0] a, input logic [3:0] b);
        return 4'((5'(a) + 5'(b)) % 16);
    endfunction

    task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // set address a quarter period after an edge, then run one edge
    task automatic apply(input logic [3:0] a);
        uaddr = a;
        @(posedge clk);
        #(CLK_PER/4);
    endtask

    task automatic run_pair(input logic [3:0] a, input logic [3:0] b);
        opnd_in = a;
        apply(4'd1); apply(4'd2);
        opnd_in = b;
        apply(4'd3); apply(4'd4); apply(4'd5); apply(4'd6);
        chk("R7 off3 forces zero", {5'd0, sum_out}, 9'd0);
        apply(4'd7);
        chk("R8 sum", {5'd0, sum_out}, {5'd0, exp_sum(a, b)});
        chk("R6 bus pin driven", {5'd0, bus_pin}, {5'd0, exp_sum(a, b)});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #(CLK_PER/4);
        uaddr = 4'd7; #1;
        chk("R9 reset sum", {5'd0, sum_out}, 9'd0);
        uaddr = 4'd0; #1;
        chk("R9 reset bus", {5'd0, bus_pin}, 9'd0);
        rst_n = 1;
        @(posedge clk); #(CLK_PER/4);

        for (int a = 0; a < 16; a++) begin
            uaddr = 4'(a); #1;
            chk((a == 0) ? "R1 idle word" : (a < 8) ? "R2 step word" : "R3 unlisted word",
                ctrl_word, exp_word(4'(a)));
        end

        run_pair(4'd15, 4'd1);
        run_pair(4'd15, 4'd15);
        run_pair(4'd0, 4'd0);

        // R4 / R6: buffer write releases the pin; load arrives on the edge
        opnd_in = 4'd9; uaddr = 4'd1; ext_val = 4'hA; ext_en = 1; #1;
        chk("R6 pin released during write", {5'd0, bus_pin}, 9'h00A);
        @(posedge clk); #(CLK_PER/4);
        ext_en = 0;
        apply(4'd0);
        chk("R4 buffer load", {5'd0, bus_pin}, 9'd9);
        chk("R5 hold idle", {5'd0, bus_pin}, 9'd9);
        apply(4'd7);
        chk("R7 reg3 held", {5'd0, sum_out}, 9'd0);

        // R3 unlisted: reg3 drives display, bus keeps value
        run_pair(4'd6, 4'd7);
        opnd_in = 4'd2;
        apply(4'd11); apply(4'd11);
        chk("R3 unlisted shows reg3", {5'd0, sum_out}, 9'd13);
        chk("R3 unlisted bus held", {5'd0, bus_pin}, 9'd13);

        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                run_pair(4'(a), 4'(b));

        void'($urandom(32'd1234));
        for (int n = 0; n < 60; n++) begin
            logic [3:0] ra, rb;
            ra = 4'($urandom); rb = 4'($urandom);
            run_pair(ra, rb);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule